// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block gives a processor two 8-bit parallel ports, A and B, behind a four-location register window. Each port has an output latch, a per-bit direction mask and a control byte. It also has two handshake lines. The first is always an input and only sets a flag. The second is either an input that sets a flag or an output that the block drives. Each port raises its own active-high interrupt request when an enabled flag is set.

A port's data location is shared between two registers, and the port's control byte picks which one is reached. Accessing the data register has side effects. Reading it clears the port's flags. On port A a read drives a handshake strobe, and on port B a write does. The strobe ends either on the next bus-clock enable or on the next active edge of the first handshake line. All pin and handshake inputs pass through a two-flop synchronizer before they are used.

Top module: `par_io_adapter`

## Requirements
- R1: Register select decodes as 0 = port A data/direction, 1 = control A, 2 = port B data/direction, 3 = control B. At offsets 0 and 2, control bit 2 = 1 reaches the output latch and 0 reaches the direction mask. A direction read returns the mask as stored, and the latch and mask appear on the port's output and direction pins.
- R2: A data read with control bit 2 = 1 returns, per bit, the latch bit where the mask bit is 1 and the synchronized pin where it is 0.
- R3: A control read returns {C1 flag, C2 flag, bits 5..0}, with bit 7 the C1 flag and bit 6 the C2 flag. A control write changes only bits 5..0, and the flags cannot be written.
- R4: A first-handshake edge sets the C1 flag when its direction matches control bit 1 (1 = rising, 0 = falling). A data read with control bit 2 = 1 clears both flags of that port.
- R5: With control bit 5 = 0 the second line is an input, and its edge sets the C2 flag when the edge matches control bit 4 (1 = rising, 0 = falling). With bit 5 = 1 the line is an output, its enable is high, edges on it set nothing, and bit 6 reads 0.
- R6: A port's interrupt is high when (C1 flag and control bit 0) or (C2 flag and bit 5 = 0 and bit 3 = 1).
- R7: In set/reset mode (bits 5..4 = 11) the second-line output equals control bit 3 from the cycle after the control write.
- R8: In strobe mode (bits 5..4 = 10) the second-line output goes low after a port A data read or a port B data write, with bit 2 = 1 in both cases.
- R9: In strobe mode with bit 3 = 1 the line returns high on the next cycle with the E enable high. With bit 3 = 0 it returns high on the next active first-handshake edge.
- R10: After reset every register and flag is zero, so all pins are inputs, both interrupts are low, and both second-line outputs are high.
- R11: A pin change is seen by a data read after two clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_en | input | 1 | Bus-clock enable used to end a strobe |
| cs | input | 1 | Chip select |
| rsel | input | 2 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (zero when not reading) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_dir | output | 8 | Port A direction mask (1 = drive) |
| ha1_in | input | 1 | Port A first handshake line |
| ha2_in | input | 1 | Port A second handshake line, input level |
| ha2_out | output | 1 | Port A second handshake line, driven level |
| ha2_oe | output | 1 | Port A second handshake line is an output |
| irq_a | output | 1 | Port A interrupt request |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_dir | output | 8 | Port B direction mask |
| hb1_in | input | 1 | Port B first handshake line |
| hb2_in | input | 1 | Port B second handshake line, input level |
| hb2_out | output | 1 | Port B second handshake line, driven level |
| hb2_oe | output | 1 | Port B second handshake line is an output |
| irq_b | output | 1 | Port B interrupt request |

## Verification
The properties assume that rd and wr are never high in the same cycle. They also assume that a data read and a handshake edge in the same port do not coincide, since the edge would win and the flag would stay set. The stimulus runs one bus operation at a time. After each handshake change it waits until the edge has cleared the synchronizer before the next access, so both assumptions hold. The E enable stays high except in one directed case that holds it low to watch a strobe wait.

// File: rtl/par_io_pkg.sv
package par_io_pkg;
  localparam int CFG_W = 6;
  // control bit positions whose meaning the logic depends on
  localparam int CB_C1_IE   = 0;
  localparam int CB_C1_RISE = 1;
  localparam int CB_DSEL    = 2;
  localparam int CB_C2_AUX  = 3;
  localparam int CB_C2_RISE = 4;
  localparam int CB_C2_OUT  = 5;

  typedef enum logic [1:0] {
    RS_DATA_A = 2'd0,
    RS_CFG_A  = 2'd1,
    RS_DATA_B = 2'd2,
    RS_CFG_B  = 2'd3
  } rsel_e;

  function automatic logic is_strobe(input logic [CFG_W-1:0] c);
    return c[CB_C2_OUT] & ~c[CB_C2_RISE];
  endfunction

  function automatic logic is_manual(input logic [CFG_W-1:0] c);
    return c[CB_C2_OUT] & c[CB_C2_RISE];
  endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/pio_c2_ctl.sv
module pio_c2_ctl
  import par_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e_en,
  input  logic [CFG_W-1:0] cfg,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_new,
  input  logic             trig,
  input  logic             c1_evt,
  output logic             c2_q
);
  logic c2_d;
  logic release_now;

  assign release_now = cfg[CB_C2_AUX] ? e_en : c1_evt;

  always_comb begin
    c2_d = c2_q;
    if (cfg_wr && is_manual(cfg_new)) begin
      c2_d = cfg_new[CB_C2_AUX];
    end else if (is_strobe(cfg)) begin
      if (trig)             c2_d = 1'b0;
      else if (release_now) c2_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c2_q <= 1'b1;
    else        c2_q <= c2_d;
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import par_io_pkg::*;
#(
  parameter int DW           = 8,
  parameter bit STROBE_ON_WR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e_en,
  input  logic             acc_data,
  input  logic             acc_cfg,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    pin_s,
  input  logic             c1_s,
  input  logic             c2_s,
  output logic [DW-1:0]    out_q,
  output logic [DW-1:0]    dir_q,
  output logic [DW-1:0]    data_view,
  output logic [7:0]       cfg_view,
  output logic             c2_out,
  output logic             c2_oe,
  output logic             irq,
  output logic [CFG_W-1:0] cfg_q,
  output logic [1:0]       flags_q,
  output logic [1:0]       evt
);
  logic [DW-1:0]    out_d, dir_d;
  logic [CFG_W-1:0] cfg_d;
  logic [1:0]       flags_d;
  logic             c1_prev_q, c2_prev_q;
  logic             rd_out, wr_out, wr_dir, wr_cfg, trig;
  logic             c1_evt, c2_evt;

  assign rd_out = acc_data & rd & cfg_q[CB_DSEL];
  assign wr_out = acc_data & wr & cfg_q[CB_DSEL];
  assign wr_dir = acc_data & wr & ~cfg_q[CB_DSEL];
  assign wr_cfg = acc_cfg & wr;

  generate
    if (STROBE_ON_WR) begin : g_trig_wr
      assign trig = wr_out;
    end else begin : g_trig_rd
      assign trig = rd_out;
    end
  endgenerate

  assign c1_evt = (c1_s ^ c1_prev_q) & (c1_s == cfg_q[CB_C1_RISE]);
  assign c2_evt = (c2_s ^ c2_prev_q) & (c2_s == cfg_q[CB_C2_RISE]) & ~cfg_q[CB_C2_OUT];
  assign evt    = {c1_evt, c2_evt};

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    cfg_d = cfg_q;
    if (wr_out) out_d = wdata;
    if (wr_dir) dir_d = wdata;
    if (wr_cfg) cfg_d = wdata[CFG_W-1:0];
    // a new edge outweighs a clearing read in the same cycle
    flags_d[1] = c1_evt | (flags_q[1] & ~rd_out);
    flags_d[0] = c2_evt | (flags_q[0] & ~rd_out);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      dir_q     <= '0;
      cfg_q     <= '0;
      flags_q   <= '0;
      c1_prev_q <= 1'b0;
      c2_prev_q <= 1'b0;
    end else begin
      if (wr_out) out_q <= out_d;
      if (wr_dir) dir_q <= dir_d;
      if (wr_cfg) cfg_q <= cfg_d;
      flags_q   <= flags_d;
      c1_prev_q <= c1_s;
      c2_prev_q <= c2_s;
    end
  end

  pio_c2_ctl u_c2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .e_en    (e_en),
    .cfg     (cfg_q),
    .cfg_wr  (wr_cfg),
    .cfg_new (wdata[CFG_W-1:0]),
    .trig    (trig),
    .c1_evt  (c1_evt),
    .c2_q    (c2_out)
  );

  assign c2_oe     = cfg_q[CB_C2_OUT];
  assign data_view = cfg_q[CB_DSEL] ? ((out_q & dir_q) | (pin_s & ~dir_q)) : dir_q;
  assign cfg_view  = {flags_q[1], flags_q[0] & ~cfg_q[CB_C2_OUT], cfg_q};
  assign irq       = (flags_q[1] & cfg_q[CB_C1_IE]) |
                     (flags_q[0] & ~cfg_q[CB_C2_OUT] & cfg_q[CB_C2_AUX]);
endmodule

// File: rtl/par_io_adapter.sv
module par_io_adapter
  import par_io_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_en,
  input  logic          cs,
  input  logic [1:0]    rsel,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_dir,
  input  logic          ha1_in,
  input  logic          ha2_in,
  output logic          ha2_out,
  output logic          ha2_oe,
  output logic          irq_a,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_dir,
  input  logic          hb1_in,
  input  logic          hb2_in,
  output logic          hb2_out,
  output logic          hb2_oe,
  output logic          irq_b
);
  localparam int NP = 2;
  localparam int SW = DW + 2;

  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic [NP-1:0][SW-1:0]    sy_d, sy_q;
  logic [NP-1:0][DW-1:0]    out_w, dir_w, dview_w;
  logic [NP-1:0][7:0]       cview_w;
  logic [NP-1:0][CFG_W-1:0] cfg_w;
  logic [NP-1:0][1:0]       flg_w, evt_w;
  logic [NP-1:0]            c2o_w, c2oe_w, irq_w, acc_data, acc_cfg;

  assign sy_d[0] = {ha2_in, ha1_in, pa_in};
  assign sy_d[1] = {hb2_in, hb1_in, pb_in};

  for (genvar gi = 0; gi < NP; gi++) begin : g_port
    sync_2ff #(.W(SW)) u_sync (
      .clk   (clk),
      .rst_n (rst_ni),
      .d     (sy_d[gi]),
      .q     (sy_q[gi])
    );

    assign acc_data[gi] = cs & (rsel == 2'(2 * gi));
    assign acc_cfg[gi]  = cs & (rsel == 2'(2 * gi + 1));

    pio_port #(.DW(DW), .STROBE_ON_WR(gi == 1)) u_port (
      .clk       (clk),
      .rst_n     (rst_ni),
      .e_en      (e_en),
      .acc_data  (acc_data[gi]),
      .acc_cfg   (acc_cfg[gi]),
      .rd        (rd),
      .wr        (wr),
      .wdata     (wdata),
      .pin_s     (sy_q[gi][DW-1:0]),
      .c1_s      (sy_q[gi][DW]),
      .c2_s      (sy_q[gi][DW+1]),
      .out_q     (out_w[gi]),
      .dir_q     (dir_w[gi]),
      .data_view (dview_w[gi]),
      .cfg_view  (cview_w[gi]),
      .c2_out    (c2o_w[gi]),
      .c2_oe     (c2oe_w[gi]),
      .irq       (irq_w[gi]),
      .cfg_q     (cfg_w[gi]),
      .flags_q   (flg_w[gi]),
      .evt       (evt_w[gi])
    );
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      unique case (rsel_e'(rsel))
        RS_DATA_A: rdata = dview_w[0];
        RS_CFG_A:  rdata = DW'(cview_w[0]);
        RS_DATA_B: rdata = dview_w[1];
        RS_CFG_B:  rdata = DW'(cview_w[1]);
        default:   rdata = '0;
      endcase
    end
  end

  assign pa_out  = out_w[0];
  assign pa_dir  = dir_w[0];
  assign ha2_out = c2o_w[0];
  assign ha2_oe  = c2oe_w[0];
  assign irq_a   = irq_w[0];
  assign pb_out  = out_w[1];
  assign pb_dir  = dir_w[1];
  assign hb2_out = c2o_w[1];
  assign hb2_oe  = c2oe_w[1];
  assign irq_b   = irq_w[1];
endmodule

// File: rtl/par_io_adapter_chk.sv
module par_io_adapter_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       cs,
  input logic       rd,
  input logic       wr,
  input logic [1:0] rsel,
  input logic       ha2_out,
  input logic       hb2_out,
  input logic       irq_a,
  input logic [5:0] cfg_a,
  input logic [5:0] cfg_b,
  input logic [1:0] flg_a,
  input logic [1:0] evt_a
);
  // R7: manual mode output follows the stored level bit
  a_r7_manual_level_a: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_a[5:4] == 2'b11) |-> (ha2_out == cfg_a[3]));
  a_r7_manual_level_b: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_b[5:4] == 2'b11) |-> (hb2_out == cfg_b[3]));

  // R4: clearing read leaves no flag when no edge competes
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs && rd && rsel == 2'd0 && cfg_a[2] && evt_a == 2'b00) |=> (flg_a == 2'b00));

  // R8: strobes go low after the triggering access
  a_r8_strobe_read_a: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs && rd && rsel == 2'd0 && cfg_a[2] && cfg_a[5:4] == 2'b10) |=> !ha2_out);
  a_r8_strobe_write_b: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs && wr && rsel == 2'd2 && cfg_b[2] && cfg_b[5:4] == 2'b10) |=> !hb2_out);

  // R5: an output-mode line never raises its flag
  a_r5_no_flag_as_output: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_a[5] && !flg_a[0]) |=> !flg_a[0]);

  // R6: with the line as output only the first flag can interrupt
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_a && cfg_a[5]) |-> (flg_a[1] && cfg_a[0]));
endmodule

bind par_io_adapter par_io_adapter_chk u_chk (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .cs      (cs),
  .rd      (rd),
  .wr      (wr),
  .rsel    (rsel),
  .ha2_out (ha2_out),
  .hb2_out (hb2_out),
  .irq_a   (irq_a),
  .cfg_a   (cfg_w[0]),
  .cfg_b   (cfg_w[1]),
  .flg_a   (flg_w[0]),
  .evt_a   (evt_w[0])
);

// File: tb/par_io_adapter_tb.sv
module par_io_adapter_tb;
  logic clk = 1'b0;
  logic rst_n, e_en, cs, rd, wr;
  logic [1:0] rsel;
  logic [7:0] wdata, rdata;
  logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
  logic ha2_out, ha2_oe, irq_a, hb2_out, hb2_oe, irq_b;
  logic [7:0] pin_drv [2];
  logic c1_drv [2];
  logic c2_drv [2];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_out [2];
  logic [7:0] m_dir [2];
  logic [5:0] m_cfg [2];
  logic       m_f1 [2];
  logic       m_f2 [2];
  logic       m_c2 [2];

  always #4 clk = ~clk;

  par_io_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .e_en(e_en), .cs(cs), .rsel(rsel), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pin_drv[0]), .pa_out(pa_out), .pa_dir(pa_dir),
    .ha1_in(c1_drv[0]), .ha2_in(c2_drv[0]), .ha2_out(ha2_out), .ha2_oe(ha2_oe), .irq_a(irq_a),
    .pb_in(pin_drv[1]), .pb_out(pb_out), .pb_dir(pb_dir),
    .hb1_in(c1_drv[1]), .hb2_in(c2_drv[1]), .hb2_out(hb2_out), .hb2_oe(hb2_oe), .irq_b(irq_b)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq(int p);
    return (m_f1[p] & m_cfg[p][0]) | (m_f2[p] & ~m_cfg[p][5] & m_cfg[p][3]);
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] rs);
    int p = rs[1];
    if (rs[0]) return {m_f1[p], m_f2[p] & ~m_cfg[p][5], m_cfg[p]};
    if (m_cfg[p][2]) return (m_out[p] & m_dir[p]) | (pin_drv[p] & ~m_dir[p]);
    return m_dir[p];
  endfunction

  // strobe with bus-clock release ends once an enabled cycle passes
  task automatic e_release();
    for (int p = 0; p < 2; p++)
      if (m_cfg[p][5:4] == 2'b10 && m_cfg[p][3] && e_en) m_c2[p] = 1'b1;
  endtask

  task automatic post_check();
    chk("R6 irq_a", {7'd0, irq_a}, {7'd0, exp_irq(0)});
    chk("R6 irq_b", {7'd0, irq_b}, {7'd0, exp_irq(1)});
    chk("R7 ha2_out", {7'd0, ha2_out}, {7'd0, m_c2[0]});
    chk("R7 hb2_out", {7'd0, hb2_out}, {7'd0, m_c2[1]});
    chk("R5 ha2_oe", {7'd0, ha2_oe}, {7'd0, m_cfg[0][5]});
    chk("R5 hb2_oe", {7'd0, hb2_oe}, {7'd0, m_cfg[1][5]});
    chk("R1 pa_out", pa_out, m_out[0]);
    chk("R1 pa_dir", pa_dir, m_dir[0]);
    chk("R1 pb_out", pb_out, m_out[1]);
    chk("R1 pb_dir", pb_dir, m_dir[1]);
  endtask

  task automatic bwr(logic [1:0] rs, logic [7:0] d);
    int p = rs[1];
    @(negedge clk); cs = 1; wr = 1; rsel = rs; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
    if (rs[0]) begin
      m_cfg[p] = d[5:0];
      if (d[5:4] == 2'b11) m_c2[p] = d[3];
    end else if (m_cfg[p][2]) begin
      m_out[p] = d;
      if (p == 1 && m_cfg[1][5:4] == 2'b10) m_c2[1] = 1'b0;
    end else begin
      m_dir[p] = d;
    end
    e_release();
    @(negedge clk);
    post_check();
  endtask

  task automatic brd(logic [1:0] rs, string req);
    int p = rs[1];
    @(negedge clk); cs = 1; rd = 1; rsel = rs;
    #2 chk(req, rdata, exp_read(rs));
    @(negedge clk); cs = 0; rd = 0;
    if (!rs[0] && m_cfg[p][2]) begin
      m_f1[p] = 1'b0; m_f2[p] = 1'b0;
      if (p == 0 && m_cfg[0][5:4] == 2'b10) m_c2[0] = 1'b0;
    end
    e_release();
    @(negedge clk);
    post_check();
  endtask

  task automatic set_pin(int p, logic [7:0] v);
    @(negedge clk); pin_drv[p] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_hs(int p, bit second, logic v);
    logic old;
    old = second ? c2_drv[p] : c1_drv[p];
    @(negedge clk);
    if (second) c2_drv[p] = v; else c1_drv[p] = v;
    repeat (4) @(negedge clk);
    if (old != v) begin
      if (!second && v == m_cfg[p][1]) begin
        m_f1[p] = 1'b1;
        if (m_cfg[p][5:4] == 2'b10 && !m_cfg[p][3]) m_c2[p] = 1'b1;
      end
      if (second && !m_cfg[p][5] && v == m_cfg[p][4]) m_f2[p] = 1'b1;
    end
    post_check();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; e_en = 1; cs = 0; rd = 0; wr = 0; rsel = 0; wdata = 0;
    for (int p = 0; p < 2; p++) begin
      pin_drv[p] = 8'h00; c1_drv[p] = 0; c2_drv[p] = 0;
      m_out[p] = 0; m_dir[p] = 0; m_cfg[p] = 0; m_f1[p] = 0; m_f2[p] = 0; m_c2[p] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R10: reset state
    post_check();
    for (int r = 0; r < 4; r++) brd(2'(r), "R10 reset read");

    // R1 / R2: direction then latch, mixed read
    bwr(2'd0, 8'hF0);
    brd(2'd0, "R1 dir read");
    bwr(2'd1, 8'h04);
    bwr(2'd0, 8'hA5);
    set_pin(0, 8'h3C);
    brd(2'd0, "R2 mixed read");

    // R11: two-edge latency on port B
    bwr(2'd3, 8'h04);
    @(negedge clk); pin_drv[1] = 8'h96; cs = 1; rd = 1; rsel = 2'd2;
    #2 chk("R11 before edges", rdata, 8'h00);
    @(negedge clk); #2 chk("R11 after one edge", rdata, 8'h00);
    @(negedge clk); #2 chk("R11 after two edges", rdata, 8'h96);
    @(negedge clk); cs = 0; rd = 0;
    @(negedge clk);

    // R3 / R4: flag set by rising first-line edge, read-only, cleared by data read
    bwr(2'd1, 8'h07);
    set_hs(0, 0, 1'b1);
    brd(2'd1, "R4 flag set");
    bwr(2'd1, 8'hC7);
    brd(2'd1, "R3 flags read-only");
    brd(2'd0, "R4 clearing read");
    brd(2'd1, "R4 flags cleared");
    set_hs(0, 0, 1'b0);

    // R5: edges ignored as output, then active as input
    bwr(2'd1, 8'h30);
    set_hs(0, 1, 1'b1);
    set_hs(0, 1, 1'b0);
    bwr(2'd1, 8'h1C);
    brd(2'd1, "R5 no flag from output mode");
    set_hs(0, 1, 1'b1);
    brd(2'd1, "R5 rising edge flag");
    bwr(2'd1, 8'h3C);
    brd(2'd1, "R5 flag masked as output");

    // R7: manual level
    bwr(2'd3, 8'h38);
    bwr(2'd3, 8'h30);
    bwr(2'd3, 8'h38);

    // R8 / R9: port B write strobe released by first-line edge
    bwr(2'd3, 8'h26);
    bwr(2'd2, 8'h55);
    chk("R8 write strobe low", {7'd0, hb2_out}, 8'h00);
    set_hs(1, 0, 1'b1);
    chk("R9 released by edge", {7'd0, hb2_out}, 8'h01);

    // R9: port A read strobe held while bus enable stays low
    e_en = 0;
    bwr(2'd1, 8'h2C);
    brd(2'd0, "R8 read strobe data");
    chk("R8 read strobe low", {7'd0, ha2_out}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 held without enable", {7'd0, ha2_out}, 8'h00);
    e_en = 1;
    @(negedge clk); e_en = 0;
    m_c2[0] = 1'b1;
    chk("R9 released by enable", {7'd0, ha2_out}, 8'h01);
    e_en = 1;
    @(negedge clk);

    // random mix
    for (int i = 0; i < 500; i++) begin
      int op = int'($urandom % 6);
      int p  = int'($urandom % 2);
      case (op)
        0: bwr(2'($urandom), 8'($urandom));
        1: brd(2'($urandom), "R1 random read");
        2: set_pin(p, 8'($urandom));
        3: set_hs(p, bit'($urandom), 1'($urandom));
        4: bwr(2'(2 * p + 1), 8'($urandom) | 8'h04);
        default: brd(2'(2 * p), "R2 random data read");
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule